// File: doc/BRIEF.md
# Selectable Link Event Counter

This block is a performance counter for the transaction layer of a serial link. Software programs an 8-bit selector code and a credit threshold. The block then accumulates exactly one kind of event into a saturating count that software can clear. The inputs fall into three kinds.

- **Per-cycle strobes:** transmit stalls, retransmissions, received messages and received packets.
- **Level comparisons on credit values:** the link partner's credits against the threshold, and the local credits against zero. These are edge-detected, so an excursion counts once no matter how long it lasts.
- **A dword indicator:** it can add one or two in a single cycle.

The selector is sampled every cycle, and a code takes effect in the cycle in which it is presented. A cycle in which the selector differs from its value in the previous cycle suppresses the edge-detected events. This prevents a spurious count when software switches between credit types.

Top module: `linkev_counter`

## Requirements
- R1: After reset the count output reads zero.
- R2: With code 0x27, 0x28, 0x29, 0x35 or 0x36 selected, the count grows by one in each cycle in which, respectively, the credit-stall, retransmit, retry-full-stall, good-message or good-packet strobe is high. The other strobes have no effect.
- R3: With code 0x2A, the count grows by one in each cycle in which the retry packet strobe is high and the retry-buffer occupancy is strictly less than the threshold. Occupancy equal to the threshold does not count.
- R4: Codes 0x2B..0x2F select the partner credit types posted header, posted data, non-posted header, completion header and completion data. Type k sits at bits [k*CRED_W +: CRED_W] of `peer_cred_i`. The count grows by one only in a cycle in which the selected credit is strictly below the threshold after having been at or above it in the previous cycle. Unselected types have no effect.
- R5: Codes 0x30..0x33 select the local credit types posted header, non-posted header, posted data and non-posted data. Type k sits at bits [k*CRED_W +: CRED_W] of `local_cred_i`. The count grows by one only in a cycle in which the selected credit is zero after having been nonzero in the previous cycle. Time spent at zero adds nothing.
- R6: Out of reset, every credit condition is treated as already true. A credit that is below the threshold or at zero from reset onward produces no count until it first leaves that condition.
- R7: With code 0x34, the count grows by one when the dword-valid input is high, and by two when dword-valid and dword-two are both high. Dword-two alone has no effect.
- R8: With any code outside 0x27..0x36, the count holds its value whatever the event inputs do.
- R9: In a cycle in which the selector differs from its value in the previous cycle, a credit edge produces no count.
- R10: The count saturates at all ones and never wraps or decreases except on clear.
- R11: A high clear input sets the count to zero on the next clock edge, even when an increment is due in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_i | input | 8 | Event selector code |
| thresh_i | input | CRED_W | Threshold for retry occupancy and partner credits |
| clr_i | input | 1 | Synchronous clear of the count |
| tx_stall_cred_i | input | 1 | Transmit stalled on missing partner credit (per packet) |
| tx_retx_i | input | 1 | Packet retransmitted |
| tx_stall_retry_i | input | 1 | Transmit stalled on full retry buffer (per packet) |
| retry_pkt_i | input | 1 | Packet strobe at which retry occupancy is evaluated |
| retry_occ_i | input | CRED_W | Retry-buffer occupancy |
| peer_cred_i | input | 5*CRED_W | Partner credit values, five types packed |
| local_cred_i | input | 4*CRED_W | Local credit values, four types packed |
| rx_dw_vld_i | input | 1 | At least one received dword this cycle |
| rx_dw_two_i | input | 1 | Two received dwords this cycle (with valid) |
| rx_msg_ok_i | input | 1 | Good message packet received |
| rx_pkt_ok_i | input | 1 | Good memory, I/O or config packet delivered |
| count_o | output | CNT_W | Event count |

## Verification
Each strobe code is driven with random activity on all strobes at once, which separates the selected source from its neighbours. The credit codes are driven with long excursions, re-entries, a value exactly at the threshold and excursions of unselected types. These tell edge counting apart from level counting, a strict comparison from an inclusive one, and correct type ordering from a swapped one. A credit edge is placed in the same cycle as a selector change, and a run of two-dword cycles pushes the count into saturation. Clear is then raised together with an increment, which shows whether clear wins.

// File: rtl/linkev_pkg.sv
package linkev_pkg;
    localparam int N_PEER  = 5;
    localparam int N_LOCAL = 4;

    localparam logic [7:0] SEL_STALL_CRED  = 8'h27;
    localparam logic [7:0] SEL_RETX        = 8'h28;
    localparam logic [7:0] SEL_STALL_RETRY = 8'h29;
    localparam logic [7:0] SEL_RETRY_LOW   = 8'h2A;
    localparam logic [7:0] SEL_PEER_BASE   = 8'h2B;
    localparam logic [7:0] SEL_LOCAL_BASE  = 8'h30;
    localparam logic [7:0] SEL_RX_DW       = 8'h34;
    localparam logic [7:0] SEL_RX_MSG      = 8'h35;
    localparam logic [7:0] SEL_RX_PKT      = 8'h36;

    typedef logic [1:0] incr_t;
endpackage

// File: rtl/linkev_edge.sv
module linkev_edge #(
    parameter int N         = 5,
    parameter int W         = 12,
    parameter bit ZERO_MODE = 1'b0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N*W-1:0] cred_i,
    input  logic [W-1:0]   thr_i,
    input  logic           hold_i,
    output logic [N-1:0]   rise_o
);
    typedef struct packed {
        logic [N-1:0] prev;
    } state_t;

    state_t       st_d, st_q;
    logic [N-1:0] cond;

    always_comb begin
        for (int k = 0; k < N; k++) begin
            cond[k] = ZERO_MODE ? (cred_i[k*W +: W] == '0)
                                : (cred_i[k*W +: W] < thr_i);
        end
        st_d.prev = cond;
        rise_o    = cond & ~st_q.prev & {N{~hold_i}};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.prev <= '1;
        else        st_q      <= st_d;
    end

    for (genvar i = 0; i < N; i++) begin : g_chk
        // An excursion counts once: no event in two consecutive cycles (R4, R5)
        p_edge_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
            rise_o[i] |=> !rise_o[i]);
    end
endmodule

// File: rtl/linkev_decode.sv
module linkev_decode
    import linkev_pkg::*;
#(
    parameter int CRED_W = 12
) (
    input  logic [7:0]        sel_i,
    input  logic [CRED_W-1:0] thr_i,
    input  logic              tx_stall_cred_i,
    input  logic              tx_retx_i,
    input  logic              tx_stall_retry_i,
    input  logic              retry_pkt_i,
    input  logic [CRED_W-1:0] retry_occ_i,
    input  logic [N_PEER-1:0] peer_rise_i,
    input  logic [N_LOCAL-1:0] local_rise_i,
    input  logic              rx_dw_vld_i,
    input  logic              rx_dw_two_i,
    input  logic              rx_msg_ok_i,
    input  logic              rx_pkt_ok_i,
    output incr_t             inc_o,
    output logic              mapped_o
);
    always_comb begin
        inc_o    = '0;
        mapped_o = 1'b1;
        unique case (sel_i)
            SEL_STALL_CRED:  inc_o = {1'b0, tx_stall_cred_i};
            SEL_RETX:        inc_o = {1'b0, tx_retx_i};
            SEL_STALL_RETRY: inc_o = {1'b0, tx_stall_retry_i};
            SEL_RETRY_LOW:   inc_o = {1'b0, retry_pkt_i && (retry_occ_i < thr_i)};
            SEL_RX_DW:       inc_o = rx_dw_vld_i ? (rx_dw_two_i ? 2'd2 : 2'd1) : 2'd0;
            SEL_RX_MSG:      inc_o = {1'b0, rx_msg_ok_i};
            SEL_RX_PKT:      inc_o = {1'b0, rx_pkt_ok_i};
            default: begin
                mapped_o = 1'b0;
                for (int k = 0; k < N_PEER; k++) begin
                    if (sel_i == SEL_PEER_BASE + 8'(k)) begin
                        mapped_o = 1'b1;
                        inc_o    = {1'b0, peer_rise_i[k]};
                    end
                end
                for (int k = 0; k < N_LOCAL; k++) begin
                    if (sel_i == SEL_LOCAL_BASE + 8'(k)) begin
                        mapped_o = 1'b1;
                        inc_o    = {1'b0, local_rise_i[k]};
                    end
                end
            end
        endcase
    end
endmodule

// File: rtl/linkev_satcnt.sv
module linkev_satcnt
    import linkev_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  incr_t        inc_i,
    output logic [W-1:0] cnt_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } state_t;

    state_t     st_d, st_q;
    logic [W:0] sum;

    always_comb begin
        sum = {1'b0, st_q.cnt} + (W+1)'(inc_i);
        st_d = st_q;
        if (clr_i)       st_d.cnt = '0;
        else if (sum[W]) st_d.cnt = '1;
        else             st_d.cnt = sum[W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.cnt <= '0;
        else        st_q     <= st_d;
    end

    assign cnt_o = st_q.cnt;

    p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_o == '0));
    p_sat_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && (&cnt_o)) |=> (&cnt_o));
    p_no_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> (cnt_o >= $past(cnt_o)));
    p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((cnt_o - $past(cnt_o)) <= W'(2)));
endmodule

// File: rtl/linkev_counter.sv
module linkev_counter
    import linkev_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int CRED_W = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [7:0]                sel_i,
    input  logic [CRED_W-1:0]         thresh_i,
    input  logic                      clr_i,
    input  logic                      tx_stall_cred_i,
    input  logic                      tx_retx_i,
    input  logic                      tx_stall_retry_i,
    input  logic                      retry_pkt_i,
    input  logic [CRED_W-1:0]         retry_occ_i,
    input  logic [N_PEER*CRED_W-1:0]  peer_cred_i,
    input  logic [N_LOCAL*CRED_W-1:0] local_cred_i,
    input  logic                      rx_dw_vld_i,
    input  logic                      rx_dw_two_i,
    input  logic                      rx_msg_ok_i,
    input  logic                      rx_pkt_ok_i,
    output logic [CNT_W-1:0]          count_o
);
    typedef struct packed {
        logic [7:0] sel;
    } state_t;

    state_t             st_d, st_q;
    logic               sel_chg;
    logic [N_PEER-1:0]  peer_rise;
    logic [N_LOCAL-1:0] local_rise;
    incr_t              inc;
    logic               mapped;

    always_comb begin
        st_d     = st_q;
        st_d.sel = sel_i;
        sel_chg  = (sel_i != st_q.sel);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.sel <= '0;
        else        st_q     <= st_d;
    end

    linkev_edge #(.N(N_PEER), .W(CRED_W), .ZERO_MODE(1'b0)) u_peer_edge (
        .clk(clk), .rst_n(rst_n), .cred_i(peer_cred_i), .thr_i(thresh_i),
        .hold_i(sel_chg), .rise_o(peer_rise)
    );

    linkev_edge #(.N(N_LOCAL), .W(CRED_W), .ZERO_MODE(1'b1)) u_local_edge (
        .clk(clk), .rst_n(rst_n), .cred_i(local_cred_i), .thr_i(thresh_i),
        .hold_i(sel_chg), .rise_o(local_rise)
    );

    linkev_decode #(.CRED_W(CRED_W)) u_decode (
        .sel_i(sel_i), .thr_i(thresh_i),
        .tx_stall_cred_i(tx_stall_cred_i), .tx_retx_i(tx_retx_i),
        .tx_stall_retry_i(tx_stall_retry_i), .retry_pkt_i(retry_pkt_i),
        .retry_occ_i(retry_occ_i), .peer_rise_i(peer_rise),
        .local_rise_i(local_rise), .rx_dw_vld_i(rx_dw_vld_i),
        .rx_dw_two_i(rx_dw_two_i), .rx_msg_ok_i(rx_msg_ok_i),
        .rx_pkt_ok_i(rx_pkt_ok_i), .inc_o(inc), .mapped_o(mapped)
    );

    linkev_satcnt #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .inc_i(inc), .cnt_o(count_o)
    );

    p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !mapped) |=> $stable(count_o));
    p_sel_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && sel_chg && (sel_i >= SEL_PEER_BASE) && (sel_i < SEL_RX_DW))
        |=> $stable(count_o));
endmodule

// File: tb/linkev_counter_bench.sv
module linkev_counter_bench;
    localparam int CNT_W  = 10;
    localparam int CRED_W = 8;
    localparam int MAXV   = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [7:0]          sel = '0;
    logic [CRED_W-1:0]   thr = '0, occ = '0;
    logic clr = 0, st_cred = 0, retx = 0, st_retry = 0, retry_pkt = 0;
    logic dw_v = 0, dw_two = 0, msg_ok = 0, pkt_ok = 0;
    logic [CRED_W-1:0]   pc [5];
    logic [CRED_W-1:0]   lc [4];
    logic [5*CRED_W-1:0] peer_flat;
    logic [4*CRED_W-1:0] local_flat;
    logic [CNT_W-1:0]    count;

    always_comb begin
        for (int k = 0; k < 5; k++) peer_flat[k*CRED_W +: CRED_W] = pc[k];
        for (int k = 0; k < 4; k++) local_flat[k*CRED_W +: CRED_W] = lc[k];
    end

    linkev_counter #(.CNT_W(CNT_W), .CRED_W(CRED_W)) u_linkev_counter (
        .clk(clk), .rst_n(rst_n), .sel_i(sel), .thresh_i(thr), .clr_i(clr),
        .tx_stall_cred_i(st_cred), .tx_retx_i(retx), .tx_stall_retry_i(st_retry),
        .retry_pkt_i(retry_pkt), .retry_occ_i(occ), .peer_cred_i(peer_flat),
        .local_cred_i(local_flat), .rx_dw_vld_i(dw_v), .rx_dw_two_i(dw_two),
        .rx_msg_ok_i(msg_ok), .rx_pkt_ok_i(pkt_ok), .count_o(count)
    );

    int checks = 0, errs = 0;
    int m_cnt = 0;
    int m_sel = 0;
    bit m_pb [5];
    bit m_lz [4];
    bit done = 0;

    task automatic model_step();
        int inc = 0;
        bit chg = (int'(sel) != m_sel);
        case (sel)
            8'h27: inc = int'(st_cred);
            8'h28: inc = int'(retx);
            8'h29: inc = int'(st_retry);
            8'h2A: inc = (retry_pkt && occ < thr) ? 1 : 0;
            8'h34: inc = dw_v ? (dw_two ? 2 : 1) : 0;
            8'h35: inc = int'(msg_ok);
            8'h36: inc = int'(pkt_ok);
            default: inc = 0;
        endcase
        for (int k = 0; k < 5; k++) begin
            bit below = (pc[k] < thr);
            if (int'(sel) == 'h2B + k && below && !m_pb[k] && !chg) inc = 1;
            m_pb[k] = below;
        end
        for (int k = 0; k < 4; k++) begin
            bit zero = (lc[k] == 0);
            if (int'(sel) == 'h30 + k && zero && !m_lz[k] && !chg) inc = 1;
            m_lz[k] = zero;
        end
        if (clr) m_cnt = 0;
        else     m_cnt = (m_cnt + inc > MAXV) ? MAXV : m_cnt + inc;
        m_sel = int'(sel);
    endtask

    task automatic check_val(string tag, int exp);
        checks++;
        if (int'(count) != exp) begin
            errs++;
            $display("FAIL %s: count=%0d expected=%0d", tag, count, exp);
        end
    endtask

    task automatic tick(string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        check_val(tag, m_cnt);
    endtask

    task automatic quiet();
        st_cred = 0; retx = 0; st_retry = 0; retry_pkt = 0;
        dw_v = 0; dw_two = 0; msg_ok = 0; pkt_ok = 0; clr = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    endtask

    initial begin
        int base;
        logic [7:0] strobe_codes [5];
        logic [7:0] bad_codes [5];
        strobe_codes = '{8'h27, 8'h28, 8'h29, 8'h35, 8'h36};
        bad_codes    = '{8'h00, 8'h26, 8'h37, 8'hFF, 8'h80};
        for (int k = 0; k < 5; k++) begin pc[k] = '0; m_pb[k] = 1; end
        for (int k = 0; k < 4; k++) begin lc[k] = '0; m_lz[k] = 1; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check_val("R1", 0);

        // R6: local credits sit at zero from reset onward
        sel = 8'h30;
        repeat (4) tick("R6");
        check_val("R6", 0);
        lc[0] = 3; tick("R6");
        lc[0] = 0; tick("R6");
        check_val("R6", 1);
        clr = 1; tick("R11"); clr = 0;

        // R2: strobe codes under random activity on all strobes
        foreach (strobe_codes[i]) begin
            sel = strobe_codes[i];
            for (int c = 0; c < 20; c++) begin
                st_cred = 1'($urandom); retx = 1'($urandom); st_retry = 1'($urandom);
                msg_ok = 1'($urandom); pkt_ok = 1'($urandom); dw_v = 1'($urandom);
                tick("R2");
            end
        end
        quiet();

        // R3: retry occupancy against threshold, including equality
        sel = 8'h2A; thr = 8'd10;
        occ = 8'd10; retry_pkt = 1; tick("R3");
        occ = 8'd9;  tick("R3");
        for (int c = 0; c < 30; c++) begin
            retry_pkt = 1'($urandom);
            occ = 8'(5 + ($urandom % 11));
            tick("R3");
        end
        quiet();

        // R4: partner credits below threshold, edge counted
        thr = 8'd20;
        for (int k = 0; k < 5; k++) pc[k] = 8'd50;
        for (int k = 0; k < 5; k++) begin
            sel = 8'(8'h2B + k);
            tick("R4");
            base = m_cnt;
            pc[k] = 8'd5;  repeat (3) tick("R4");
            pc[k] = 8'd50; tick("R4");
            pc[k] = 8'd19; repeat (2) tick("R4");
            pc[k] = 8'd20; tick("R4");
            pc[k] = 8'd0;  tick("R4");
            pc[(k+1)%5] = 8'd1; tick("R4");
            pc[(k+1)%5] = 8'd50; tick("R4");
            check_val("R4", base + 3);
            pc[k] = 8'd50; tick("R4");
        end

        // R5: local credits reaching zero, edge counted
        for (int k = 0; k < 4; k++) lc[k] = 8'd7;
        for (int k = 0; k < 4; k++) begin
            sel = 8'(8'h30 + k);
            tick("R5");
            base = m_cnt;
            lc[k] = 8'd0; repeat (3) tick("R5");
            lc[k] = 8'd1; tick("R5");
            lc[k] = 8'd0; tick("R5");
            lc[(k+1)%4] = 8'd0; tick("R5");
            lc[(k+1)%4] = 8'd7; tick("R5");
            check_val("R5", base + 2);
            lc[k] = 8'd7; tick("R5");
        end

        // R7: dword counting with 1 or 2 per cycle
        sel = 8'h34;
        dw_v = 0; dw_two = 1; tick("R7");
        for (int c = 0; c < 40; c++) begin
            dw_v = 1'($urandom); dw_two = 1'($urandom);
            tick("R7");
        end
        quiet();

        // R8: unmapped codes hold the count
        foreach (bad_codes[i]) begin
            sel = bad_codes[i];
            base = m_cnt;
            for (int c = 0; c < 5; c++) begin
                st_cred = 1; retx = 1; st_retry = 1; retry_pkt = 1; occ = 0;
                dw_v = 1; dw_two = 1; msg_ok = 1; pkt_ok = 1;
                pc[c%5] = (c % 2 == 0) ? 8'd0 : 8'd50;
                lc[c%4] = (c % 2 == 0) ? 8'd0 : 8'd7;
                tick("R8");
            end
            check_val("R8", base);
        end
        quiet();
        for (int k = 0; k < 5; k++) pc[k] = 8'd50;
        for (int k = 0; k < 4; k++) lc[k] = 8'd7;

        // R9: credit edge in the same cycle as a selector change
        sel = 8'h27; repeat (2) tick("R9");
        base = m_cnt;
        sel = 8'h2B; pc[0] = 8'd5; tick("R9");
        repeat (3) tick("R9");
        check_val("R9", base);
        pc[0] = 8'd50; tick("R9");
        pc[0] = 8'd5;  tick("R9");
        check_val("R9", base + 1);
        pc[0] = 8'd50;

        // R10: saturation
        clr = 1; tick("R11"); clr = 0;
        sel = 8'h34; dw_v = 1; dw_two = 1;
        repeat (520) tick("R10");
        check_val("R10", MAXV);
        repeat (5) tick("R10");
        check_val("R10", MAXV);

        // R11: clear wins over same-cycle increment
        clr = 1; tick("R11");
        check_val("R11", 0);
        clr = 0; tick("R11");
        check_val("R11", 2);
        quiet();
        tick("R11");

        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            finish_run();
        end
    end
endmodule